// File: doc/BRIEF.md
# Mode-Banked Interrupt Status Controller

This block collects the event flags of an infrared serial link controller and turns them into a single interrupt request. A transfer-mode register chooses the link speed class: slow, medium or fast. The same register carries one gate bit per bank that silences that bank's interrupt. There are two status banks. One serves slow mode, and the other is shared by medium and fast modes. Each bank has a status register, a mask register and a write-one-to-clear register.

Five hardware event pulses set status bits at fixed positions. Only the bank that the current mode selects receives them. Both banks use the same bit positions. Bits 9 and 8 mean receive timeout and framing error in slow mode, and abort detected and CRC error in medium and fast modes. Software reads the active bank and acknowledges events by writing ones to that bank's clear register. Software can also mask single sources or gate a whole bank from the mode register.

All state sits on a 16-bit register bus with a word address. Reads are combinational. Writes and events take effect at the next rising clock edge. The asynchronous active-low reset is released synchronously inside the block.

Top module: `mbk_irq_ctrl`

## Requirements
- R1: After reset the mode word reads 0x0111, both status registers read 0x0000, both mask registers read 0x8B80, and `irq` is low.
- R2: An event pulse sets its status bit in the active bank only. Frame-receive-end sets bit 15, overflow bit 11, the timeout/abort source bit 9, the framing/CRC source bit 8 and frame-transmit-end bit 7. The other bank does not change.
- R3: Mode field bits 15:14 select the bank. 00 selects the slow bank, and 10 and 11 select the medium/fast bank. Code 01 selects no bank: events are dropped and `irq` stays low.
- R4: Writing to a bank's clear register clears each status bit written as 1 and leaves the bits written as 0. A clear register always reads 0x0000.
- R5: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: `irq` is high exactly when the selected bank has a status bit set whose mask bit is 0 and that bank's gate bit in the mode word is 0. Bit 0 gates the slow bank and bit 4 gates the medium/fast bank.
- R7: Pending bits in the bank that is not selected never raise `irq`.
- R8: Writes to a status register are ignored.
- R9: A mask register stores only bits 15, 11, 9, 8 and 7. The mode word stores only bits 15, 14, 8, 4 and 0. Bit 8, the FIFO receive gate, is stored but has no effect on `irq`.
- R10: Status bits hold their value across mode changes until they are cleared.
- R11: The word address map is: 0 mode, 4/5/6 slow status/mask/clear, 8/9/10 medium/fast status/mask/clear. Any other address reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| evt_rx_end | input | 1 | Frame receive end pulse (bit 15) |
| evt_ovf | input | 1 | Buffer overflow pulse (bit 11) |
| evt_alt9 | input | 1 | Timeout or abort pulse (bit 9) |
| evt_alt8 | input | 1 | Framing or CRC error pulse (bit 8) |
| evt_tx_end | input | 1 | Frame transmit end pulse (bit 7) |
| irq | output | 1 | Interrupt request, level |

## Verification
Every register result is due at the first rising edge after the stimulus. This covers an event that sets a bit, a clear, a mask or mode write, and the `irq` change that follows from it, because `irq` and `bus_rdata` are combinational from the stored state. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then sets the read address and samples one nanosecond later, so one rising edge lies between stimulus and sample. In the same-cycle collision cases the event and the clear are driven on the same falling edge, so both reach the same rising edge.

// File: rtl/mbk_irq_pkg.sv
package mbk_irq_pkg;

  localparam int unsigned REG_W = 16;

  // status bit positions shared by both banks
  localparam int unsigned BIT_RX_END = 15;
  localparam int unsigned BIT_OVF    = 11;
  localparam int unsigned BIT_ALT9   = 9;
  localparam int unsigned BIT_ALT8   = 8;
  localparam int unsigned BIT_TX_END = 7;

  localparam logic [REG_W-1:0] SRC_USED = 16'h8B80;

  // mode word layout
  localparam int unsigned MODE_HI   = 15;
  localparam int unsigned MODE_LO   = 14;
  localparam int unsigned GATE_FIFO = 8;
  localparam int unsigned GATE_MF   = 4;
  localparam int unsigned GATE_SLOW = 0;

  localparam logic [REG_W-1:0] MODE_USED = 16'hC111;
  localparam logic [REG_W-1:0] MODE_RST  = 16'h0111;

  typedef enum logic [1:0] {
    XM_SLOW = 2'b00,
    XM_RSVD = 2'b01,
    XM_FAST = 2'b10,
    XM_MED  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_SLOW = 2'b01,
    BK_MF   = 2'b10
  } bank_sel_e;

  function automatic bank_sel_e bank_of(input logic [1:0] fld);
    bank_sel_e r;
    case (xfer_mode_e'(fld))
      XM_SLOW: r = BK_SLOW;
      XM_FAST: r = BK_MF;
      XM_MED:  r = BK_MF;
      default: r = BK_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mbk_rst_sync.sv
module mbk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_q = s2_q;
endmodule

// File: rtl/mbk_irq_mode.sv
module mbk_irq_mode
  import mbk_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_q,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] mode_word,
  output logic [1:0]       mode_fld
);
  logic [REG_W-1:0] word_q;
  logic [REG_W-1:0] word_d;
  logic             word_en;

  always_comb begin
    word_en = we;
    word_d  = wdata & MODE_USED;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      word_q <= MODE_RST;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign mode_word = word_q;
  assign mode_fld  = word_q[MODE_HI:MODE_LO];
endmodule

// File: rtl/mbk_irq_bank.sv
module mbk_irq_bank #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         USED = '1
) (
  input  logic         clk,
  input  logic         rst_q,
  input  logic [W-1:0] evt_vec,
  input  logic         evt_en,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] mask_q, mask_d;
  logic         stat_en;
  logic         mask_en;

  // clear first, then events: an event in the same cycle wins
  always_comb begin
    stat_d = stat_q;
    if (clr_we) begin
      stat_d = stat_d & ~wdata;
    end
    if (evt_en) begin
      stat_d = stat_d | evt_vec;
    end
    stat_d  = stat_d & USED;
    stat_en = clr_we | (evt_en & (|evt_vec));
  end

  always_comb begin
    mask_d  = wdata & USED;
    mask_en = mask_we;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      mask_q <= USED;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
endmodule

// File: rtl/mbk_irq_route.sv
module mbk_irq_route
  import mbk_irq_pkg::*;
#(
  parameter int unsigned NBANK = 2
) (
  input  logic [1:0]                  mode_fld,
  input  logic [NBANK-1:0]            bank_gate,
  input  logic [NBANK-1:0][REG_W-1:0] stat,
  input  logic [NBANK-1:0][REG_W-1:0] mask,
  output logic [NBANK-1:0]            evt_en,
  output logic                        irq
);
  bank_sel_e            sel;
  logic [NBANK-1:0]     pend;

  always_comb begin
    sel    = bank_of(mode_fld);
    evt_en = '0;
    case (sel)
      BK_SLOW: evt_en[0] = 1'b1;
      BK_MF:   evt_en[1] = 1'b1;
      default: evt_en    = '0;
    endcase
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_pend
    assign pend[b] = evt_en[b] & ~bank_gate[b] & (|(stat[b] & ~mask[b]));
  end

  assign irq = |pend;
endmodule

// File: rtl/mbk_irq_ctrl.sv
module mbk_irq_ctrl
  import mbk_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MODE_ADR  = 0,
  parameter int unsigned SLOW_BASE = 4,
  parameter int unsigned MF_BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              evt_rx_end,
  input  logic              evt_ovf,
  input  logic              evt_alt9,
  input  logic              evt_alt8,
  input  logic              evt_tx_end,
  output logic              irq
);
  localparam int unsigned NBANK   = 2;
  localparam int unsigned OFS_STS = 0;
  localparam int unsigned OFS_MSK = 1;
  localparam int unsigned OFS_CLR = 2;

  function automatic logic [ADDR_W-1:0] bank_base(input int unsigned b);
    return (b == 0) ? ADDR_W'(SLOW_BASE) : ADDR_W'(MF_BASE);
  endfunction

  logic                        rst_q;
  logic [REG_W-1:0]            mode_word;
  logic [1:0]                  mode_fld;
  logic                        mode_we;
  logic [REG_W-1:0]            evt_vec;
  logic [NBANK-1:0][REG_W-1:0] bk_stat;
  logic [NBANK-1:0][REG_W-1:0] bk_mask;
  logic [NBANK-1:0]            bk_clr_we;
  logic [NBANK-1:0]            bk_msk_we;
  logic [NBANK-1:0]            bk_evt_en;
  logic [NBANK-1:0]            bk_gate;
  logic [REG_W-1:0]            rd_mux;

  mbk_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    evt_vec             = '0;
    evt_vec[BIT_RX_END] = evt_rx_end;
    evt_vec[BIT_OVF]    = evt_ovf;
    evt_vec[BIT_ALT9]   = evt_alt9;
    evt_vec[BIT_ALT8]   = evt_alt8;
    evt_vec[BIT_TX_END] = evt_tx_end;
  end

  assign mode_we = bus_we && (bus_addr == ADDR_W'(MODE_ADR));

  mbk_irq_mode u_mode (
    .clk       (clk),
    .rst_q     (rst_q),
    .we        (mode_we),
    .wdata     (bus_wdata),
    .mode_word (mode_word),
    .mode_fld  (mode_fld)
  );

  assign bk_gate[0] = mode_word[GATE_SLOW];
  assign bk_gate[1] = mode_word[GATE_MF];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = (b == 0) ? ADDR_W'(SLOW_BASE) : ADDR_W'(MF_BASE);

    assign bk_msk_we[b] = bus_we && (bus_addr == BASE + ADDR_W'(OFS_MSK));
    assign bk_clr_we[b] = bus_we && (bus_addr == BASE + ADDR_W'(OFS_CLR));

    mbk_irq_bank #(
      .W    (REG_W),
      .USED (SRC_USED)
    ) u_bank (
      .clk     (clk),
      .rst_q   (rst_q),
      .evt_vec (evt_vec),
      .evt_en  (bk_evt_en[b]),
      .mask_we (bk_msk_we[b]),
      .clr_we  (bk_clr_we[b]),
      .wdata   (bus_wdata),
      .status  (bk_stat[b]),
      .mask    (bk_mask[b])
    );
  end

  mbk_irq_route #(
    .NBANK (NBANK)
  ) u_route (
    .mode_fld  (mode_fld),
    .bank_gate (bk_gate),
    .stat      (bk_stat),
    .mask      (bk_mask),
    .evt_en    (bk_evt_en),
    .irq       (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(MODE_ADR)) begin
      rd_mux = mode_word;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == bank_base(b) + ADDR_W'(OFS_STS)) begin
        rd_mux = bk_stat[b];
      end
      if (bus_addr == bank_base(b) + ADDR_W'(OFS_MSK)) begin
        rd_mux = bk_mask[b];
      end
    end
  end

  assign bus_rdata = rd_mux;
endmodule

// File: rtl/mbk_irq_ctrl_chk.sv
module mbk_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_q,
  input logic [15:0] evt_vec,
  input logic [1:0]  mode_fld,
  input logic [15:0] mode_word,
  input logic [15:0] stat_slow,
  input logic [15:0] stat_mf,
  input logic [15:0] mask_slow,
  input logic [15:0] mask_mf,
  input logic        clr_slow,
  input logic        clr_mf,
  input logic        irq
);
  logic sel_mf;
  assign sel_mf = mode_fld[1];

  // R2 and R5: an event in slow mode lands even if a clear hits the same cycle
  assert_slow_set_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_fld == 2'b00 && (|evt_vec)) |=> ((stat_slow & $past(evt_vec)) == $past(evt_vec)));

  assert_mf_set_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_mf && (|evt_vec)) |=> ((stat_mf & $past(evt_vec)) == $past(evt_vec)));

  // R2: the bank not selected stays put unless cleared
  assert_mf_idle_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (!sel_mf && !clr_mf) |=> (stat_mf == $past(stat_mf)));

  // R10: without a clear no status bit drops
  assert_slow_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !clr_slow |=> ((stat_slow & $past(stat_slow)) == $past(stat_slow)));

  assert_mf_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !clr_mf |=> ((stat_mf & $past(stat_mf)) == $past(stat_mf)));

  // R3: reserved mode keeps the line low
  assert_rsvd_quiet_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_fld == 2'b01) |-> !irq);

  // R6: bank gate silences the selected bank
  assert_slow_gate_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_fld == 2'b00 && mode_word[0]) |-> !irq);

  assert_mf_gate_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (sel_mf && mode_word[4]) |-> !irq);

  // R7: a raised line always has an unmasked cause in the selected bank
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> (sel_mf ? (|(stat_mf & ~mask_mf)) : (|(stat_slow & ~mask_slow))));
endmodule

bind mbk_irq_ctrl mbk_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .evt_vec   (evt_vec),
  .mode_fld  (mode_fld),
  .mode_word (mode_word),
  .stat_slow (bk_stat[0]),
  .stat_mf   (bk_stat[1]),
  .mask_slow (bk_mask[0]),
  .mask_mf   (bk_mask[1]),
  .clr_slow  (bk_clr_we[0]),
  .clr_mf    (bk_clr_we[1]),
  .irq       (irq)
);

// File: tb/test_mbk_irq_ctrl.sv
`timescale 1ns/1ps
module test_mbk_irq_ctrl;
  localparam logic [3:0]  A_MODE = 4'd0, A_SSTS = 4'd4, A_SMSK = 4'd5, A_SCLR = 4'd6;
  localparam logic [3:0]  A_MSTS = 4'd8, A_MMSK = 4'd9, A_MCLR = 4'd10;
  localparam logic [15:0] USED = 16'h8B80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ev_rx, ev_ov, ev_a9, ev_a8, ev_tx;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [15:0] m_mode, m_s, m_m, m_sm, m_mm;

  always #2.5 clk = ~clk;

  mbk_irq_ctrl i_mbk_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .evt_rx_end (ev_rx),
    .evt_ovf    (ev_ov),
    .evt_alt9   (ev_a9),
    .evt_alt8   (ev_a8),
    .evt_tx_end (ev_tx),
    .irq        (irq)
  );

  function automatic logic [15:0] spread(input logic [4:0] v);
    return {v[4], 3'b000, v[3], 1'b0, v[2], v[1], v[0], 7'b0};
  endfunction

  function automatic logic model_irq();
    case (m_mode[15:14])
      2'b00:        return !m_mode[0] && ((m_s & ~m_sm) != 16'h0);
      2'b10, 2'b11: return !m_mode[4] && ((m_m & ~m_mm) != 16'h0);
      default:      return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [15:0] v;
    rd(A_MODE, v); chk({tag, " mode"}, v, m_mode);
    rd(A_SSTS, v); chk({tag, " slow status"}, v, m_s);
    rd(A_SMSK, v); chk({tag, " slow mask"}, v, m_sm);
    rd(A_SCLR, v); chk({tag, " slow clear reads 0 R4"}, v, 16'h0);
    rd(A_MSTS, v); chk({tag, " mf status"}, v, m_m);
    rd(A_MMSK, v); chk({tag, " mf mask"}, v, m_mm);
    rd(A_MCLR, v); chk({tag, " mf clear reads 0 R4"}, v, 16'h0);
    chk({tag, " irq R6"}, {15'h0, irq}, {15'h0, model_irq()});
  endtask

  // one rising edge with optional events and optional bus write
  task automatic step(input logic [4:0] ev, input logic we, input logic [3:0] a,
                      input logic [15:0] d);
    logic [1:0] old_fld;
    @(negedge clk);
    {ev_rx, ev_ov, ev_a9, ev_a8, ev_tx} = ev;
    bus_we = we; bus_addr = a; bus_wdata = d;
    old_fld = m_mode[15:14];
    @(negedge clk);
    {ev_rx, ev_ov, ev_a9, ev_a8, ev_tx} = 5'b0;
    bus_we = 1'b0;
    if (we) begin
      case (a)
        A_MODE: m_mode = d & 16'hC111;
        A_SMSK: m_sm = d & USED;
        A_MMSK: m_mm = d & USED;
        A_SCLR: m_s = m_s & ~d;
        A_MCLR: m_m = m_m & ~d;
        default: ;
      endcase
    end
    case (old_fld)
      2'b00:        m_s = m_s | spread(ev);
      2'b10, 2'b11: m_m = m_m | spread(ev);
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(5'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    {ev_rx, ev_ov, ev_a9, ev_a8, ev_tx} = 5'b0;
    m_mode = 16'h0111; m_s = 0; m_m = 0; m_sm = USED; m_mm = USED;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_all("R1 reset");
    rd(4'd3, v);  chk("R11 unmapped", v, 16'h0);
    rd(4'd15, v); chk("R11 unmapped high", v, 16'h0);

    // R9: stored bits only
    wr(A_MODE, 16'hFFFF); check_all("R9 mode bits");
    wr(A_SMSK, 16'hFFFF); wr(A_MMSK, 16'hFFFF); check_all("R9 mask bits");

    // R2 R3: every event pattern in every mode code, masks open
    for (int md = 0; md < 4; md++) begin
      wr(A_MODE, {md[1:0], 14'h0100});
      wr(A_SMSK, 16'h0); wr(A_MMSK, 16'h0);
      for (int e = 0; e < 32; e++) begin
        step(e[4:0], 1'b0, A_MODE, 16'h0);
        check_all(md == 1 ? "R3 reserved" : "R2 event");
        wr(A_SCLR, 16'hFFFF); wr(A_MCLR, 16'hFFFF);
        check_all("R4 full clear");
      end
    end

    // R6: slow mask sweep, then slow gate, then R9 fifo gate is inert
    wr(A_MODE, 16'h0110);
    step(5'h1F, 1'b0, A_MODE, 16'h0);
    for (int k = 0; k < 32; k++) begin
      wr(A_SMSK, spread(k[4:0]));
      check_all("R6 slow mask");
    end
    wr(A_SMSK, 16'h0);
    wr(A_MODE, 16'h0101); check_all("R6 slow gate");
    wr(A_MODE, 16'h0010); check_all("R9 fifo gate no effect");
    wr(A_MODE, 16'h0000); check_all("R9 fifo gate clear");

    // R4: partial clears
    wr(A_SCLR, 16'h8080); check_all("R4 partial clear");
    wr(A_SCLR, 16'h0000); check_all("R4 zero write");

    // R8: status write ignored
    wr(A_SSTS, 16'hFFFF); check_all("R8 status write");

    // R5: event and clear of the same bit together
    step(5'b10000, 1'b1, A_SCLR, 16'hFFFF); check_all("R5 collision");
    wr(A_SCLR, 16'hFFFF);

    // R6 and R10: medium/fast bank in both of its codes
    for (int c = 2; c < 4; c++) begin
      wr(A_MODE, {c[1:0], 14'h0101});
      wr(A_MCLR, 16'hFFFF);
      step(5'h1F, 1'b0, A_MODE, 16'h0);
      for (int k = 0; k < 32; k++) begin
        wr(A_MMSK, spread(k[4:0]));
        check_all("R6 mf mask");
      end
      wr(A_MMSK, 16'h0);
      wr(A_MODE, {c[1:0], 14'h0111}); check_all("R6 mf gate");
    end

    // R7 R10: mf pending, switch to slow with empty slow bank
    wr(A_MODE, 16'hC000); check_all("R6 mf open");
    wr(A_MODE, 16'h0000); check_all("R7 inactive bank");
    step(5'b00001, 1'b0, A_MODE, 16'h0); check_all("R10 mf held in slow");
    wr(A_MODE, 16'h8000); check_all("R10 back to fast");
    step(5'b00100, 1'b1, A_MCLR, 16'h0200); check_all("R5 mf collision");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule